// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Host with Select-Level Guard

This block is a register-programmed SPI host that moves one byte per transfer. Software sets a clock rate, a clock polarity and a clock phase in a control register and then writes a byte to the data register. The block produces SCK and MOSI, shifts the byte out MSB first, and collects eight MISO bits. When the transfer ends it raises a done flag and keeps the received byte ready to be read.

The host runs only while an internal select level is high. That level comes from either the external select pin or a software bit held in a management register, and a field in the same register picks the source. If the level goes low, the block clears its host-mode and enable bits and sets a sticky fault flag. Any transfer in progress stops: SCK goes back to idle and MOSI keeps its last value. Shifting resumes only after software enables host mode again while the select level is high.

There are three registers, each eight bits wide. Address 0 is control, address 1 is management and status, and address 2 is data. Read data depends only on the address. A read strobe is needed only for reads that clear flags.

Top module: `spi_host_ssm`

## Requirements
- R1: After reset, all three registers read 0x00, `sck_o` is 0 and `mosi_o` is 0.
- R2: Control register (address 0) layout: bit 7 enable, bit 6 host mode, bit 5 CPOL, bit 4 CPHA, bits 2:0 rate code `r`. Outside a transfer, `sck_o` equals CPOL. During a transfer, each SCK level lasts 2^r system clocks, so the divide ratio is 2^(r+1), and a byte takes 16 SCK edges.
- R3: Data goes out MSB first, and bit 7 is on MOSI from the data write onward. With CPHA=0, edges 1, 3, …, 15 sample and edges 2, 4, …, 14 present the next bit. With CPHA=1, edges 2, 4, …, 16 sample and edges 3, 5, …, 15 present the next bit. This holds for both CPOL values.
- R4: A write to the data register (address 2) starts a transfer only when enable, host mode and the select level are all high and no transfer is running. Otherwise the write produces no SCK edge.
- R5: After the 16th edge, status bit 7 (done) reads 1 and the data register reads the received byte. A read of the data register with `bus_rd` high clears done.
- R6: Management register (address 1): bit 1 selects the select source and bit 0 is the software level. When bit 1 is 1 the select level is bit 0; when bit 1 is 0 it is `ss_pin`.
- R7: While the select level is low, control bits 7 and 6 read 0, including right after a write that tries to set them. Status bit 5 (fault) is set if either bit was set or was being written as 1.
- R8: A low select level during a transfer returns SCK to idle within one clock. After that there are no more SCK edges, MOSI keeps its value and done is not set. Fault stays set until a control write made while the select level is high.
- R9: A data write during a transfer does not change the byte being sent or the byte being received, and it sets status bit 6 (collision). A read of address 1 with `bus_rd` high clears collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Read strobe; triggers clear-on-read side effects |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ss_pin | input | 1 | External select level |
| miso_i | input | 1 | Serial data from the peripheral |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the peripheral |

## Verification
A wrong phase or edge counter shows up at once on `sck_o`. The level fails to return to CPOL at the end of a byte, or an edge gap differs from 2^r clocks. An error in the sample/launch assignment appears one byte later as a corrupted MOSI capture or a wrong received byte. A stuck select mux or fault path shows one clock after the level change, as control bits that read back set or as an SCK that keeps toggling after the select level drops.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    localparam int DATA_W = 8;
    localparam int RATE_W = 3;
    localparam int DIV_W  = (1 << RATE_W) - 1;
    localparam int EDGES  = 2 * DATA_W;
    localparam int EDGE_W = $clog2(EDGES + 1);

    typedef enum logic [1:0] {
        RA_CTRL  = 2'd0,
        RA_MGMT  = 2'd1,
        RA_DATA  = 2'd2,
        RA_SPARE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              run_en;
        logic              host_sel;
        logic              cpol;
        logic              cpha;
        logic [RATE_W-1:0] rate;
    } ctrl_t;

    typedef struct packed {
        logic done;
        logic coll;
        logic fault;
    } flags_t;

    function automatic ctrl_t ctrl_from_byte(input logic [DATA_W-1:0] b);
        ctrl_t c;
        c.run_en   = b[7];
        c.host_sel = b[6];
        c.cpol     = b[5];
        c.cpha     = b[4];
        c.rate     = b[RATE_W-1:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_byte(input ctrl_t c);
        logic [DATA_W-1:0] b;
        b             = '0;
        b[7]          = c.run_en;
        b[6]          = c.host_sel;
        b[5]          = c.cpol;
        b[4]          = c.cpha;
        b[RATE_W-1:0] = c.rate;
        return b;
    endfunction

    function automatic logic [DATA_W-1:0] mgmt_to_byte(input flags_t f, input logic ssm,
                                                       input logic ssi);
        logic [DATA_W-1:0] b;
        b    = '0;
        b[7] = f.done;
        b[6] = f.coll;
        b[5] = f.fault;
        b[1] = ssm;
        b[0] = ssi;
        return b;
    endfunction

    // Edge numbering starts at 1; CPHA=0 samples on odd edges, CPHA=1 on even ones.
    function automatic logic is_sample_edge(input logic [EDGE_W-1:0] n, input logic cpha);
        return n[0] ^ cpha;
    endfunction

endpackage

// File: rtl/spi_edge_gen.sv
module spi_edge_gen
    import spi_host_pkg::*;
#(
    parameter int P_RATE_W = RATE_W,
    parameter int P_DIV_W  = (1 << P_RATE_W) - 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                restart,
    input  logic [P_RATE_W-1:0] rate,
    output logic                tick
);
    logic [P_DIV_W-1:0] cnt;
    logic [P_DIV_W-1:0] lim;
    logic [P_DIV_W:0]   span;

    // half period in system clocks is 2^rate
    assign span = (P_DIV_W + 1)'(1) << rate;
    assign lim  = P_DIV_W'(span - (P_DIV_W + 1)'(1));
    assign tick = run && !restart && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + P_DIV_W'(1);
        end
    end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_host_pkg::*;
#(
    parameter int P_DATA_W = DATA_W,
    parameter int P_EDGES  = 2 * P_DATA_W,
    parameter int P_EDGE_W = $clog2(P_EDGES + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                abort,
    input  logic                tick,
    input  logic                cpol,
    input  logic                cpha,
    input  logic [P_DATA_W-1:0] tx_byte,
    input  logic                miso,
    output logic                busy,
    output logic                sck,
    output logic                mosi,
    output logic                done,
    output logic [P_DATA_W-1:0] rx_byte
);
    logic [P_EDGE_W-1:0] edge_n;
    logic [P_EDGE_W-1:0] edge_nxt;
    logic [P_DATA_W-1:0] tx_sh;
    logic [P_DATA_W-1:0] rx_sh;
    logic                phase;
    logic                sample_now;
    logic                last_edge;
    logic                first_edge;

    assign edge_nxt   = edge_n + P_EDGE_W'(1);
    assign sample_now = is_sample_edge(edge_nxt, cpha);
    assign last_edge  = (edge_nxt == P_EDGE_W'(P_EDGES));
    assign first_edge = (edge_nxt == P_EDGE_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            edge_n <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            phase  <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy   <= 1'b1;
                edge_n <= '0;
                tx_sh  <= tx_byte;
                phase  <= 1'b0;
            end else if (abort) begin
                // clock parks at idle, transmit shifter frozen
                busy   <= 1'b0;
                edge_n <= '0;
                phase  <= 1'b0;
            end else if (busy && tick) begin
                edge_n <= edge_nxt;
                phase  <= ~phase;
                if (sample_now) begin
                    rx_sh <= {rx_sh[P_DATA_W-2:0], miso};
                end else if (!first_edge && !last_edge) begin
                    tx_sh <= {tx_sh[P_DATA_W-2:0], 1'b0};
                end
                if (last_edge) begin
                    busy   <= 1'b0;
                    edge_n <= '0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assign sck     = cpol ^ phase;
    assign mosi    = tx_sh[P_DATA_W-1];
    assign rx_byte = rx_sh;
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
    import spi_host_pkg::*;
#(
    parameter int P_DATA_W = DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [1:0]          bus_addr,
    input  logic [P_DATA_W-1:0] bus_wdata,
    output logic [P_DATA_W-1:0] bus_rdata,
    input  logic                ss_pin,
    input  logic                busy,
    input  logic                xfer_done,
    input  logic [P_DATA_W-1:0] rx_byte,
    output ctrl_t               ctrl_o,
    output flags_t              flags_o,
    output logic                ss_level,
    output logic                active,
    output logic                start
);
    ctrl_t               ctrl_q;
    flags_t              flags_q;
    logic                sel_by_sw;
    logic                sel_soft;
    logic [P_DATA_W-1:0] rx_q;
    logic                wr_ctrl, wr_mgmt, wr_data, rd_mgmt, rd_data;

    assign wr_ctrl = bus_wr && (bus_addr == RA_CTRL);
    assign wr_mgmt = bus_wr && (bus_addr == RA_MGMT);
    assign wr_data = bus_wr && (bus_addr == RA_DATA);
    assign rd_mgmt = bus_rd && (bus_addr == RA_MGMT);
    assign rd_data = bus_rd && (bus_addr == RA_DATA);

    assign ss_level = sel_by_sw ? sel_soft : ss_pin;
    assign active   = ctrl_q.run_en && ctrl_q.host_sel && ss_level;
    assign start    = wr_data && active && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            flags_q   <= '0;
            sel_by_sw <= 1'b0;
            sel_soft  <= 1'b0;
            rx_q      <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= ctrl_from_byte(bus_wdata);
                if (ss_level) begin
                    flags_q.fault <= 1'b0;
                end
            end
            if (wr_mgmt) begin
                sel_by_sw <= bus_wdata[1];
                sel_soft  <= bus_wdata[0];
            end
            // low select level overrides any write to the mode bits
            if (!ss_level) begin
                ctrl_q.run_en   <= 1'b0;
                ctrl_q.host_sel <= 1'b0;
                if (ctrl_q.run_en || ctrl_q.host_sel ||
                    (wr_ctrl && (bus_wdata[7] || bus_wdata[6]))) begin
                    flags_q.fault <= 1'b1;
                end
            end
            if (rd_mgmt) begin
                flags_q.coll <= 1'b0;
            end
            if (wr_data && busy) begin
                flags_q.coll <= 1'b1;
            end
            if (rd_data) begin
                flags_q.done <= 1'b0;
            end
            if (xfer_done) begin
                flags_q.done <= 1'b1;
                rx_q         <= rx_byte;
            end
        end
    end

    always_comb begin
        unique case (bus_addr)
            RA_CTRL: bus_rdata = ctrl_to_byte(ctrl_q);
            RA_MGMT: bus_rdata = mgmt_to_byte(flags_q, sel_by_sw, sel_soft);
            RA_DATA: bus_rdata = rx_q;
            default: bus_rdata = '0;
        endcase
    end

    assign ctrl_o  = ctrl_q;
    assign flags_o = flags_q;
endmodule

// File: rtl/spi_host_ssm.sv
module spi_host_ssm
    import spi_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ss_pin,
    input  logic              miso_i,
    output logic              sck_o,
    output logic              mosi_o
);
    ctrl_t              ctrl_q;
    flags_t             flags_q;
    logic               ss_level;
    logic               host_active;
    logic               xfer_start;
    logic               xfer_busy;
    logic               xfer_done;
    logic               edge_tick;
    logic [DATA_W-1:0]  rx_byte;

    spi_host_regs #(.P_DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ss_pin    (ss_pin),
        .busy      (xfer_busy),
        .xfer_done (xfer_done),
        .rx_byte   (rx_byte),
        .ctrl_o    (ctrl_q),
        .flags_o   (flags_q),
        .ss_level  (ss_level),
        .active    (host_active),
        .start     (xfer_start)
    );

    spi_edge_gen #(.P_RATE_W(RATE_W), .P_DIV_W(DIV_W)) u_edges (
        .clk     (clk),
        .rst     (rst),
        .run     (xfer_busy),
        .restart (xfer_start),
        .rate    (ctrl_q.rate),
        .tick    (edge_tick)
    );

    spi_shift_core #(.P_DATA_W(DATA_W), .P_EDGES(EDGES), .P_EDGE_W(EDGE_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .start   (xfer_start),
        .abort   (!host_active),
        .tick    (edge_tick),
        .cpol    (ctrl_q.cpol),
        .cpha    (ctrl_q.cpha),
        .tx_byte (bus_wdata),
        .miso    (miso_i),
        .busy    (xfer_busy),
        .sck     (sck_o),
        .mosi    (mosi_o),
        .done    (xfer_done),
        .rx_byte (rx_byte)
    );
endmodule

// File: rtl/spi_host_ssm_chk.sv
module spi_host_ssm_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic active,
    input logic ss_level,
    input logic sck_o,
    input logic cpol,
    input logic run_en,
    input logic host_sel,
    input logic fault,
    input logic coll,
    input logic wr_data
);
    // R2
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sck_o == cpol));

    // R7
    mode_bits_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !ss_level |=> (!run_en && !host_sel));

    // R7
    fault_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (!ss_level && (run_en || host_sel)) |=> fault);

    // R8
    abort_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !active) |=> !busy);

    // R9
    collision_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_data && busy) |=> coll);

    // R4
    start_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(active));
endmodule

bind spi_host_ssm spi_host_ssm_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (xfer_busy),
    .active   (host_active),
    .ss_level (ss_level),
    .sck_o    (sck_o),
    .cpol     (ctrl_q.cpol),
    .run_en   (ctrl_q.run_en),
    .host_sel (ctrl_q.host_sel),
    .fault    (flags_q.fault),
    .coll     (flags_q.coll),
    .wr_data  (bus_wr && (bus_addr == 2'd2))
);

// File: tb/spi_host_ssm_test.sv
`timescale 1ns/1ps
module spi_host_ssm_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ss_pin = 1'b1;
    logic       miso_i = 1'b0;
    logic       sck_o;
    logic       mosi_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // peripheral model state
    int       cyc = 0;
    int       slv_edges = 0;
    int       last_cyc = 0;
    int       gmin = 0;
    int       gmax = 0;
    logic     sck_prev = 1'b0;
    logic     tb_cpha = 1'b0;
    logic [7:0] slv_sh = 8'd0;
    logic [7:0] mst_cap = 8'd0;

    spi_host_ssm uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ss_pin(ss_pin), .miso_i(miso_i),
        .sck_o(sck_o), .mosi_o(mosi_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc = cyc + 1;

    always @(negedge clk) begin
        if (sck_o !== sck_prev) begin
            sck_prev  = sck_o;
            slv_edges = slv_edges + 1;
            if (slv_edges > 1) begin
                if (cyc - last_cyc < gmin) gmin = cyc - last_cyc;
                if (cyc - last_cyc > gmax) gmax = cyc - last_cyc;
            end
            last_cyc = cyc;
            if (((slv_edges % 2) == 1) != tb_cpha) begin
                mst_cap = {mst_cap[6:0], mosi_o};
            end else if (slv_edges != 1 && slv_edges != 16) begin
                slv_sh = {slv_sh[6:0], 1'b0};
                miso_i = slv_sh[7];
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic arm(input logic cpha, input logic [7:0] pat);
        @(posedge clk);
        #1;
        tb_cpha = cpha; slv_sh = pat; miso_i = pat[7];
        slv_edges = 0; gmin = 1 << 20; gmax = 0; mst_cap = 8'd0; sck_prev = sck_o;
    endtask

    task automatic wait_edges(input int n);
        for (int i = 0; i < 5000 && slv_edges < n; i++) @(posedge clk);
    endtask

    task automatic start_xfer(input logic cpol, input logic cpha, input logic [2:0] rate,
                              input logic [7:0] tx, input logic [7:0] slv);
        bus_write(2'd0, {2'b11, cpol, cpha, 1'b0, rate});
        arm(cpha, slv);
        bus_write(2'd2, tx);
    endtask

    task automatic finish_xfer(input string req, input logic cpol, input logic [2:0] rate,
                               input logic [7:0] tx, input logic [7:0] slv);
        logic [7:0] v;
        wait_edges(16);
        repeat (3) @(posedge clk);
        chk(req, "edge count", slv_edges, 16);
        chk("R2", "min half period", gmin, 1 << rate);
        chk("R2", "max half period", gmax, 1 << rate);
        chk("R3", "mosi bits seen by peripheral", mst_cap, tx);
        chk("R2", "sck idle after byte", sck_o, cpol);
        peek(2'd1, v);
        chk("R5", "done flag set", v[7], 1);
        bus_read(2'd2, v);
        chk("R5", "received byte", v, slv);
        peek(2'd1, v);
        chk("R5", "done cleared by data read", v[7], 0);
    endtask

    task automatic test_reset;
        logic [7:0] v;
        chk("R1", "sck after reset", sck_o, 0);
        chk("R1", "mosi after reset", mosi_o, 0);
        peek(2'd0, v); chk("R1", "ctrl reset", v, 8'h00);
        peek(2'd1, v); chk("R1", "mgmt reset", v, 8'h00);
        peek(2'd2, v); chk("R1", "data reset", v, 8'h00);
    endtask

    task automatic test_modes;
        bus_write(2'd0, 8'h20);
        @(negedge clk);
        chk("R2", "idle high with CPOL=1", sck_o, 1);
        start_xfer(1'b0, 1'b0, 3'd0, 8'hA5, 8'h3C); finish_xfer("R3", 1'b0, 3'd0, 8'hA5, 8'h3C);
        start_xfer(1'b0, 1'b1, 3'd1, 8'h5A, 8'hC3); finish_xfer("R3", 1'b0, 3'd1, 8'h5A, 8'hC3);
        start_xfer(1'b1, 1'b0, 3'd2, 8'h81, 8'h7E); finish_xfer("R3", 1'b1, 3'd2, 8'h81, 8'h7E);
        start_xfer(1'b1, 1'b1, 3'd3, 8'h1F, 8'hE0); finish_xfer("R3", 1'b1, 3'd3, 8'h1F, 8'hE0);
        start_xfer(1'b0, 1'b1, 3'd7, 8'h96, 8'h69); finish_xfer("R2", 1'b0, 3'd7, 8'h96, 8'h69);
    endtask

    task automatic test_no_enable;
        logic [7:0] v;
        bus_write(2'd0, 8'h40);
        arm(1'b0, 8'h00);
        bus_write(2'd2, 8'hFF);
        repeat (40) @(posedge clk);
        chk("R4", "no edges without enable", slv_edges, 0);
        peek(2'd1, v);
        chk("R4", "no done without enable", v[7], 0);
    endtask

    task automatic test_select_mux;
        logic [7:0] v;
        bus_write(2'd1, 8'h03);
        @(negedge clk); ss_pin = 1'b0;
        start_xfer(1'b0, 1'b0, 3'd1, 8'hC7, 8'h2B);
        finish_xfer("R6", 1'b0, 3'd1, 8'hC7, 8'h2B);
        peek(2'd0, v);
        chk("R6", "software level keeps host mode with pin low", v[7:6], 2'b11);
        bus_write(2'd1, 8'h02);
        peek(2'd0, v);
        chk("R6", "software level low clears mode bits", v[7:6], 2'b00);
        peek(2'd1, v);
        chk("R7", "fault set by software level", v[5], 1);
        bus_write(2'd1, 8'h00);
        bus_write(2'd0, 8'hC0);
        peek(2'd0, v);
        chk("R7", "mode bits refuse to set with pin low", v[7:6], 2'b00);
        peek(2'd1, v);
        chk("R8", "fault kept after write with pin low", v[5], 1);
        @(negedge clk); ss_pin = 1'b1;
        bus_write(2'd0, 8'hC0);
        peek(2'd0, v);
        chk("R7", "mode bits set with pin high", v[7:6], 2'b11);
        peek(2'd1, v);
        chk("R8", "fault cleared by control write", v[5], 0);
    endtask

    task automatic test_abort;
        logic [7:0] v;
        int e_snap;
        logic m_snap;
        start_xfer(1'b1, 1'b0, 3'd3, 8'hB4, 8'h4B);
        wait_edges(5);
        @(negedge clk); ss_pin = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R8", "sck idle after abort", sck_o, 1);
        e_snap = slv_edges;
        m_snap = mosi_o;
        repeat (100) @(posedge clk);
        #1;
        chk("R8", "no edges after abort", slv_edges, e_snap);
        chk("R8", "mosi held after abort", mosi_o, m_snap);
        peek(2'd1, v);
        chk("R8", "no done after abort", v[7], 0);
        chk("R7", "fault after abort", v[5], 1);
        @(negedge clk); ss_pin = 1'b1;
        start_xfer(1'b0, 1'b1, 3'd0, 8'h3D, 8'hD3);
        finish_xfer("R8", 1'b0, 3'd0, 8'h3D, 8'hD3);
    endtask

    task automatic test_collision;
        logic [7:0] v;
        start_xfer(1'b0, 1'b0, 3'd2, 8'h3A, 8'hC5);
        wait_edges(3);
        bus_write(2'd2, 8'hFF);
        peek(2'd1, v);
        chk("R9", "collision flag set", v[6], 1);
        finish_xfer("R9", 1'b0, 3'd2, 8'h3A, 8'hC5);
        bus_read(2'd1, v);
        peek(2'd1, v);
        chk("R9", "collision cleared by status read", v[6], 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        test_reset;
        test_modes;
        test_no_enable;
        test_select_mux;
        test_abort;
        test_collision;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule